// File: doc/BRIEF.md
# Integer Unit Issue Scoreboard

This block sits at the issue point of a two-ALU integer cluster. At most one decoded operation arrives per cycle on a valid/ready port. Each operation carries a 4-bit class code and a size flag (0 = 32-bit, 1 = 64-bit). The scoreboard decides which ALU takes the operation and keeps one down-counter per ALU for how long that ALU stays occupied. It holds the operation back when the ALU it needs is taken. It also keeps two readiness timers, one for the LO result and one for the HI result of a multiply or divide. A later read of LO or HI waits until its own timer has run out.

The steering is deliberately lopsided. Shifts, branches, jumps, calls, integer conditional moves and moves to the coprocessor can only run on ALU1. Multiply and divide can only run on ALU2, and they hold it for many cycles. A divide makes LO ready one cycle before HI. General arithmetic and the two result reads may use either ALU, and ALU1 is preferred. Multi-part, atomic and unknown operations claim both ALUs in the same cycle. The block performs no arithmetic itself. Latency counts are parameters. A synchronous, active-high reset clears every counter and timer.

Top module: `int_issue_sb`

## Requirements
- R1: While `rst` is high, `in_ready`, `alu1_sel` and `alu2_sel` are low. After reset every counter and timer is clear, so an operation of any class may issue in the first cycle after reset, even if a long operation was in flight when reset was applied.
- R2: Class 0 (add, subtract, logical, set-less-than, count-leading-zeros, constant, nop, trap, move to HI/LO) issues on ALU1 alone (`alu1_sel`=1, `alu2_sel`=0) and holds ALU1 for 1 cycle, so another operation may issue in the next cycle.
- R3: Classes 1 (shift), 2 (branch, jump or call), 3 (integer conditional move) and 4 (move to coprocessor) issue only on ALU1 (`alu1_sel`=1, `alu2_sel`=0) and hold it for 1 cycle.
- R4: Class 5 (multiply) issues only on ALU2. It holds ALU2 for 6 cycles when 32-bit and 10 cycles when 64-bit: a following ALU2 operation presented in the next cycle first issues 6 or 10 cycles after the multiply.
- R5: Class 6 (divide) issues only on ALU2 and holds it for 35 cycles when 32-bit and 67 cycles when 64-bit.
- R6: Class 7 (read LO) may use either ALU, with ALU1 preferred. It waits until the LO result is ready. LO is ready 6 or 10 cycles after a multiply (32/64-bit) and 34 or 66 cycles after a divide (32/64-bit).
- R7: Class 8 (read HI) may use either ALU, with ALU1 preferred. It waits until the HI result is ready. HI is ready 6 or 10 cycles after a multiply and 35 or 67 cycles after a divide.
- R8: Class 9 (multi-part, atomic, sync loop) and the unused codes 10 to 15 issue only when both ALUs are free. They assert `alu1_sel` and `alu2_sel` together.
- R9: `stall` is high exactly when `in_valid` is high and `in_ready` is low. `alu1_sel` and `alu2_sel` are high only in a cycle in which an operation issues (`in_valid` and `in_ready` both high).
- R10: Operations of classes 0 to 4 issue without waiting while ALU2 is occupied by a multiply or divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| in_class | input | 4 | Operation class code (see R2 to R8) |
| in_wide | input | 1 | Size flag: 1 = 64-bit form, 0 = 32-bit form |
| in_ready | output | 1 | The presented operation may issue this cycle |
| alu1_sel | output | 1 | The issuing operation is placed on ALU1 |
| alu2_sel | output | 1 | The issuing operation is placed on ALU2 |
| stall | output | 1 | Operation presented but held back |

## Verification
The assertions assume that `in_class` and `in_wide` stay stable while `in_valid` is high and the operation stalls. The bench follows this rule: it changes an operation only on a falling edge, after the operation has issued. The properties on ALU2 occupancy and LO/HI readiness also assume an operation is counted as issued only in a cycle where `in_valid` and `in_ready` are both high. The bench therefore never looks at the select outputs outside such a cycle, except to check that they are zero. Each sweep starts from an idle scoreboard. To get there, the bench leaves the port idle for longer than the longest occupancy before presenting the next pair of operations.

// File: rtl/int_sb_pkg.sv
package int_sb_pkg;

  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    OP_ARITH  = 4'd0,
    OP_SHIFT  = 4'd1,
    OP_BRANCH = 4'd2,
    OP_CMOVE  = 4'd3,
    OP_TOCOP  = 4'd4,
    OP_MUL    = 4'd5,
    OP_DIV    = 4'd6,
    OP_RDLO   = 4'd7,
    OP_RDHI   = 4'd8,
    OP_MULTI  = 4'd9
  } op_class_e;

  typedef enum logic [1:0] {
    RT_EITHER = 2'd0,
    RT_ONLY1  = 2'd1,
    RT_ONLY2  = 2'd2,
    RT_BOTH   = 2'd3
  } route_e;

  function automatic route_e class_route(input logic [CLASS_W-1:0] cls);
    route_e r;
    case (cls)
      OP_ARITH, OP_RDLO, OP_RDHI:               r = RT_EITHER;
      OP_SHIFT, OP_BRANCH, OP_CMOVE, OP_TOCOP:  r = RT_ONLY1;
      OP_MUL, OP_DIV:                           r = RT_ONLY2;
      default:                                  r = RT_BOTH;
    endcase
    return r;
  endfunction

  function automatic logic is_long(input logic [CLASS_W-1:0] cls);
    return (cls == OP_MUL) || (cls == OP_DIV);
  endfunction

  // Occupancy of ALU2 in cycles, including the issue cycle.
  function automatic int alu2_occupancy(input logic [CLASS_W-1:0] cls, input logic wide,
                                        input int mul32, input int mul64,
                                        input int div32_lo, input int div64_lo);
    int c;
    if (cls == OP_MUL)      c = wide ? mul64 : mul32;
    else if (cls == OP_DIV) c = wide ? (div64_lo + 1) : (div32_lo + 1);
    else                    c = 1;
    return c;
  endfunction

  // Cycles from issue until the LO (hi_half=0) or HI (hi_half=1) result is readable.
  function automatic int result_latency(input logic [CLASS_W-1:0] cls, input logic wide,
                                        input logic hi_half,
                                        input int mul32, input int mul64,
                                        input int div32_lo, input int div64_lo);
    int c;
    if (cls == OP_MUL)      c = wide ? mul64 : mul32;
    else if (cls == OP_DIV) c = (wide ? div64_lo : div32_lo) + (hi_half ? 1 : 0);
    else                    c = 1;
    return c;
  endfunction

  // A counter loaded with cycles-1 at issue reaches zero exactly when the wait is over.
  function automatic int hold_value(input int cycles);
    return (cycles > 0) ? (cycles - 1) : 0;
  endfunction

endpackage

// File: rtl/sb_countdown.sv
module sb_countdown #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/sb_steer.sv
module sb_steer
  import int_sb_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  input  logic               a1_free,
  input  logic               a2_free,
  input  logic               lo_rdy,
  input  logic               hi_rdy,
  output logic               can_go,
  output logic               pick1,
  output logic               pick2
);
  route_e route;
  logic   opnd_ok;
  logic   unit_ok;

  assign route = class_route(cls);

  always_comb begin
    case (cls)
      OP_RDLO: opnd_ok = lo_rdy;
      OP_RDHI: opnd_ok = hi_rdy;
      default: opnd_ok = 1'b1;
    endcase
  end

  always_comb begin
    pick1   = 1'b0;
    pick2   = 1'b0;
    unit_ok = 1'b0;
    case (route)
      RT_EITHER: begin
        pick1   = a1_free;
        pick2   = !a1_free && a2_free;
        unit_ok = a1_free || a2_free;
      end
      RT_ONLY1: begin
        pick1   = 1'b1;
        unit_ok = a1_free;
      end
      RT_ONLY2: begin
        pick2   = 1'b1;
        unit_ok = a2_free;
      end
      default: begin
        pick1   = 1'b1;
        pick2   = 1'b1;
        unit_ok = a1_free && a2_free;
      end
    endcase
  end

  assign can_go = unit_ok && opnd_ok;
endmodule

// File: rtl/int_issue_sb.sv
module int_issue_sb
  import int_sb_pkg::*;
#(
  parameter int MUL32_CYC  = 6,
  parameter int MUL64_CYC  = 10,
  parameter int DIV32_LO   = 34,
  parameter int DIV64_LO   = 66
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [CLASS_W-1:0] in_class,
  input  logic               in_wide,
  output logic               in_ready,
  output logic               alu1_sel,
  output logic               alu2_sel,
  output logic               stall
);
  localparam int LONGEST = (DIV64_LO > DIV32_LO) ? DIV64_LO + 2 : DIV32_LO + 2;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int NCNT    = 4;   // 0: ALU1, 1: ALU2, 2: LO timer, 3: HI timer

  logic          fire;
  logic          can_go, pick1, pick2;
  logic          a1_free, a2_free, lo_ready, hi_ready;
  logic [NCNT-1:0]        cnt_load;
  logic [NCNT-1:0][CW-1:0] cnt_val;
  logic [NCNT-1:0]        cnt_idle;

  assign a1_free  = cnt_idle[0];
  assign a2_free  = cnt_idle[1];
  assign lo_ready = cnt_idle[2];
  assign hi_ready = cnt_idle[3];

  sb_steer u_steer (
    .cls     (in_class),
    .a1_free (a1_free),
    .a2_free (a2_free),
    .lo_rdy  (lo_ready),
    .hi_rdy  (hi_ready),
    .can_go  (can_go),
    .pick1   (pick1),
    .pick2   (pick2)
  );

  assign in_ready = !rst && can_go;
  assign fire     = in_valid && in_ready;
  assign alu1_sel = fire && pick1;
  assign alu2_sel = fire && pick2;
  assign stall    = in_valid && !in_ready;

  assign cnt_load[0] = alu1_sel;
  assign cnt_val[0]  = CW'(hold_value(1));
  assign cnt_load[1] = alu2_sel;
  assign cnt_val[1]  = CW'(hold_value(alu2_occupancy(in_class, in_wide,
                         MUL32_CYC, MUL64_CYC, DIV32_LO, DIV64_LO)));
  assign cnt_load[2] = fire && is_long(in_class);
  assign cnt_val[2]  = CW'(hold_value(result_latency(in_class, in_wide, 1'b0,
                         MUL32_CYC, MUL64_CYC, DIV32_LO, DIV64_LO)));
  assign cnt_load[3] = fire && is_long(in_class);
  assign cnt_val[3]  = CW'(hold_value(result_latency(in_class, in_wide, 1'b1,
                         MUL32_CYC, MUL64_CYC, DIV32_LO, DIV64_LO)));

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sb_countdown #(.W(CW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load[g]),
      .load_val (cnt_val[g]),
      .idle     (cnt_idle[g])
    );
  end
endmodule

// File: rtl/int_sb_checker.sv
module int_sb_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [3:0] in_class,
  input logic       in_ready,
  input logic       alu1_sel,
  input logic       alu2_sel,
  input logic       stall,
  input logic       lo_ready,
  input logic       hi_ready
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> (!in_ready && !alu1_sel && !alu2_sel));

  a_r2_either_one_unit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_class == 4'd0) |-> $onehot({alu1_sel, alu2_sel}));

  a_r3_alu1_only: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_class >= 4'd1 && in_class <= 4'd4) |-> (alu1_sel && !alu2_sel));

  a_r4_long_holds_alu2: assert property (@(posedge clk) disable iff (rst)
    (alu2_sel && (in_class == 4'd5 || in_class == 4'd6)) |=> !alu2_sel);

  a_r6_lo_wait: assert property (@(posedge clk) disable iff (rst)
    ((alu1_sel || alu2_sel) && in_class == 4'd7) |-> lo_ready);

  a_r7_hi_wait: assert property (@(posedge clk) disable iff (rst)
    ((alu1_sel || alu2_sel) && in_class == 4'd8) |-> hi_ready);

  a_r8_both_units: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_class >= 4'd9) |-> (alu1_sel && alu2_sel));

  a_r9_sel_only_on_issue: assert property (@(posedge clk) disable iff (rst)
    (alu1_sel || alu2_sel) |-> (in_valid && in_ready && !stall));

  a_r9_stall_no_sel: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!alu1_sel && !alu2_sel && !in_ready));
endmodule

bind int_issue_sb int_sb_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_class (in_class),
  .in_ready (in_ready),
  .alu1_sel (alu1_sel),
  .alu2_sel (alu2_sel),
  .stall    (stall),
  .lo_ready (lo_ready),
  .hi_ready (hi_ready)
);

// File: tb/test_int_issue_sb.sv
module test_int_issue_sb;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] in_class;
  logic       in_wide;
  logic       in_ready, alu1_sel, alu2_sel, stall;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  int_issue_sb i_int_issue_sb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class), .in_wide(in_wide),
    .in_ready(in_ready), .alu1_sel(alu1_sel), .alu2_sel(alu2_sel), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected selections on an idle scoreboard: {alu1, alu2}.
  function automatic int idle_sel(input int cls);
    if (cls <= 4 || cls == 7 || cls == 8) return 2;
    if (cls == 5 || cls == 6) return 1;
    return 3;
  endfunction

  // Expected wait, in cycles after the lead issues, before the follower issues.
  function automatic int follow_wait(input int lead, input bit wide, input int fol);
    int busy, lo, hi;
    if (lead == 5) begin
      busy = wide ? 10 : 6; lo = busy; hi = busy;
    end else begin
      lo = wide ? 66 : 34; hi = lo + 1; busy = hi;
    end
    if (fol == 5 || fol == 6 || fol == 9) return busy;
    if (fol == 7) return lo;
    if (fol == 8) return hi;
    return 1;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_for(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int followers[7] = '{5, 6, 7, 8, 9, 0, 1};

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_class = 4'd0; in_wide = 1'b0;
    @(negedge clk); tick();
    #1;
    check(!in_ready && !alu1_sel && !alu2_sel, "R1 reset quiet", {in_ready, alu1_sel, alu2_sel}, 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    #1;
    check(!stall && !alu1_sel && !alu2_sel, "R9 idle no select", {stall, alu1_sel, alu2_sel}, 0);

    // Selection on an idle scoreboard, every class code and both sizes.
    for (int c = 0; c < 16; c++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        in_valid = 1'b1; in_class = 4'(c); in_wide = w[0];
        #1;
        if (c == 0) check({alu1_sel, alu2_sel} == 2'(idle_sel(c)), "R2 either class picks ALU1", {alu1_sel, alu2_sel}, idle_sel(c));
        else if (c <= 4) check({alu1_sel, alu2_sel} == 2'(idle_sel(c)), "R3 ALU1-only class", {alu1_sel, alu2_sel}, idle_sel(c));
        else if (c <= 6) check({alu1_sel, alu2_sel} == 2'(idle_sel(c)), "R4 R5 ALU2-only class", {alu1_sel, alu2_sel}, idle_sel(c));
        else if (c <= 8) check({alu1_sel, alu2_sel} == 2'(idle_sel(c)), "R6 R7 result read picks ALU1", {alu1_sel, alu2_sel}, idle_sel(c));
        else check({alu1_sel, alu2_sel} == 2'(idle_sel(c)), "R8 both units", {alu1_sel, alu2_sel}, idle_sel(c));
        check(in_ready && !stall, "R9 ready when idle", {in_ready, stall}, 2);
        tick();
        idle_for(70);
      end
    end

    // Back-to-back single-cycle operations.
    for (int c = 0; c < 5; c++) begin
      in_valid = 1'b1; in_class = 4'(c); in_wide = 1'b0;
      #1;
      check(in_ready && alu1_sel, "R2 R3 back-to-back issue", {in_ready, alu1_sel}, 3);
      tick();
    end
    idle_for(2);

    // Lead long operation followed by each follower class.
    for (int lead = 5; lead <= 6; lead++) begin
      for (int w = 0; w < 2; w++) begin
        foreach (followers[f]) begin
          int k, exp_k, fol;
          bit seen_stall;
          fol = followers[f];
          exp_k = follow_wait(lead, w[0], fol);
          in_valid = 1'b1; in_class = 4'(lead); in_wide = w[0];
          #1;
          check(in_ready && alu2_sel && !alu1_sel, "R4 R5 lead on ALU2", {in_ready, alu1_sel, alu2_sel}, 5);
          tick();
          in_class = 4'(fol); in_wide = w[0];
          k = 1; seen_stall = 1'b0;
          #1;
          while (!in_ready && k < 200) begin
            if (!seen_stall) begin
              check(stall && !alu1_sel && !alu2_sel, "R9 stall without select", {stall, alu1_sel, alu2_sel}, 4);
              seen_stall = 1'b1;
            end
            tick(); k++;
            #1;
          end
          if (fol == 5 || fol == 6 || fol == 9)
            check(k == exp_k, lead == 5 ? "R4 ALU2 hold after multiply" : "R5 ALU2 hold after divide", k, exp_k);
          else if (fol == 7) check(k == exp_k, "R6 LO ready time", k, exp_k);
          else if (fol == 8) check(k == exp_k, "R7 HI ready time", k, exp_k);
          else check(k == exp_k, "R10 ALU1 work during long op", k, exp_k);
          check({alu1_sel, alu2_sel} == 2'(idle_sel(fol)), "R9 follower select", {alu1_sel, alu2_sel}, idle_sel(fol));
          tick();
          idle_for(75);
        end
      end
    end

    // Reset in the middle of a 64-bit divide clears the occupancy.
    in_valid = 1'b1; in_class = 4'd6; in_wide = 1'b1;
    tick();
    rst = 1'b1; in_class = 4'd8;
    #1;
    check(!in_ready && !alu1_sel && !alu2_sel, "R1 ready low in reset", {in_ready, alu1_sel, alu2_sel}, 0);
    tick();
    rst = 1'b0;
    #1;
    check(in_ready && alu1_sel, "R1 HI read free after reset", {in_ready, alu1_sel}, 3);
    in_class = 4'd5;
    #1;
    check(in_ready && alu2_sel, "R1 ALU2 free after reset", {in_ready, alu2_sel}, 3);
    tick();
    in_valid = 1'b0;
    idle_for(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule